// File: doc/BRIEF.md
# Dual-Domain Random Number Splitter

This block takes numbers from a single on-demand random source and shares them between two consumers. Each consumer runs on its own clock, and that clock can be gated. The source hands over one number per valid/ready handshake on the source clock. The block keeps two eight-entry dual-clock FIFOs topped up. Every number it accepts goes to exactly one of the FIFOs. When both FIFOs have room, a round-robin pointer decides which one gets the next number.

Each consumer sees a pull port driven straight from the head of its FIFO. The read pointer crosses into the source domain as a Gray code through two flops, and the write pointer crosses the other way in the same manner. Full is judged on the write side and empty on the read side, and both are conservative. Each of the three domains has its own reset input. The block asserts each reset asynchronously and releases it after two edges of that domain's clock.

Top module: `rng_splitter`

## Requirements
- R1: While a domain is in reset and until data reaches a FIFO, `src_ready`, `a_valid` and `b_valid` are 0.
- R2: A number is taken when `src_valid` and `src_ready` are both 1 at a rising edge of `src_clk`. At most one number is taken per edge, and it is written into exactly one FIFO.
- R3: `src_ready` is 1 whenever either FIFO has room. With both consumers stalled, exactly 16 numbers are accepted (8 per FIFO) and `src_ready` then stays 0.
- R4: When both FIFOs have room, fills alternate between them, and the first fill after reset goes to port A. From empty, port A therefore holds source items 0,2,4,… and port B holds items 1,3,5,….
- R5: `x_valid` is 1 exactly when the FIFO is non-empty, and `x_data` is its oldest entry. An entry is removed at a rising edge of `x_clk` when `x_valid`, `x_ready` and `x_gate` are all 1. Each port delivers its items in source order.
- R6: While `x_gate` is 0, the read side of that port makes no progress and `x_ready` has no effect. The buffered data is kept and is delivered once the gate opens.
- R7: A read with `x_valid` at 0 yields no item. A source offer while both FIFOs are full is not taken.
- R8: Over any mix of clock ratios, gating patterns and source stalls, every accepted number is delivered exactly once on one of the ports.
- R9: After a reset input is released, that domain stays in reset for two rising edges of its own clock. `src_ready` first rises after the second `src_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_arst_n | input | 1 | Source-domain asynchronous reset, active low |
| src_valid | input | 1 | Source offers a number |
| src_data | input | 16 | Offered number |
| src_ready | output | 1 | Block takes the offered number |
| a_clk | input | 1 | Consumer A clock |
| a_arst_n | input | 1 | Consumer A reset, active low |
| a_gate | input | 1 | Consumer A clock gate (1 = running) |
| a_ready | input | 1 | Consumer A pulls |
| a_valid | output | 1 | Port A has data |
| a_data | output | 16 | Head of FIFO A |
| b_clk | input | 1 | Consumer B clock |
| b_arst_n | input | 1 | Consumer B reset, active low |
| b_gate | input | 1 | Consumer B clock gate (1 = running) |
| b_ready | input | 1 | Consumer B pulls |
| b_valid | output | 1 | Port B has data |
| b_data | output | 16 | Head of FIFO B |

## Verification
The bench first fills both FIFOs while both gates are closed and holds `x_ready` high. The accepted count must stop at exactly 16, and nothing may leave either port. A design with a wrong full comparison would over-accept and overwrite data, and one that ignores the gate would leak items early. The first items drained must follow the even/odd split. A broken round-robin would give port A consecutive source items.

The bench then runs ratios of 4, 6 and 10 ns. Consumer A pulls at a steady one-in-three and consumer B in bursts, while the source stalls and gate A toggles at random. A Gray-code or synchroniser fault would show up as a duplicated, lost or reordered item. The bench also times the release of the source reset edge by edge.

// File: rtl/rng_splitter.sv
module rng_splitter #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          src_clk,
  input  logic          src_arst_n,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          src_ready,
  input  logic          a_clk,
  input  logic          a_arst_n,
  input  logic          a_gate,
  input  logic          a_ready,
  output logic          a_valid,
  output logic [DW-1:0] a_data,
  input  logic          b_clk,
  input  logic          b_arst_n,
  input  logic          b_gate,
  input  logic          b_ready,
  output logic          b_valid,
  output logic [DW-1:0] b_data
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [1:0] s_rs;
  logic       src_rst_n;
  always_ff @(posedge src_clk or negedge src_arst_n)
    if (!src_arst_n) s_rs <= '0;
    else             s_rs <= {s_rs[0], 1'b1};
  assign src_rst_n = s_rs[1];

  logic [1:0]    rclk, rarst_n, rgate, rreq, rvalid, rrst_n, ren;
  logic [1:0]    full, room, wen;
  logic [DW-1:0] rdata [2];
  logic [PW-1:0] rpos  [2];
  logic          pri, sel, acc;

  assign rclk    = {b_clk, a_clk};
  assign rarst_n = {b_arst_n, a_arst_n};
  assign rgate   = {b_gate, a_gate};
  assign rreq    = {b_ready, a_ready};

  assign room      = ~full & {2{src_rst_n}};
  assign src_ready = |room;
  assign acc       = src_valid & src_ready;
  assign sel       = (room == 2'b11) ? pri : room[1];
  assign wen       = acc ? (sel ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) pri <= 1'b0;
    else if (acc)   pri <= ~sel;

  for (genvar i = 0; i < 2; i++) begin : g_fifo
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rs1, rs2;
    logic [PW-1:0] rbin, rgray, ws1, ws2;
    logic [1:0]    rst_s;

    always_ff @(posedge rclk[i] or negedge rarst_n[i])
      if (!rarst_n[i]) rst_s <= '0;
      else             rst_s <= {rst_s[0], 1'b1};
    assign rrst_n[i] = rst_s[1];

    always_ff @(posedge src_clk or negedge src_rst_n)
      if (!src_rst_n) begin
        wbin <= '0; wgray <= '0; rs1 <= '0; rs2 <= '0;
      end else begin
        rs1 <= rgray;
        rs2 <= rs1;
        if (wen[i]) begin
          wbin  <= wbin + 1'b1;
          wgray <= b2g(wbin + 1'b1);
        end
      end

    always_ff @(posedge src_clk)
      if (wen[i]) mem[wbin[AW-1:0]] <= src_data;

    assign full[i] = (wgray == {~rs2[PW-1:PW-2], rs2[PW-3:0]});

    always_ff @(posedge rclk[i] or negedge rrst_n[i])
      if (!rrst_n[i]) begin
        rbin <= '0; rgray <= '0; ws1 <= '0; ws2 <= '0;
      end else begin
        ws1 <= wgray;
        ws2 <= ws1;
        if (ren[i]) begin
          rbin  <= rbin + 1'b1;
          rgray <= b2g(rbin + 1'b1);
        end
      end

    assign rvalid[i] = (rgray != ws2);
    assign ren[i]    = rvalid[i] & rreq[i] & rgate[i];
    assign rdata[i]  = mem[rbin[AW-1:0]];
    assign rpos[i]   = rbin;
  end

  assign a_valid = rvalid[0];
  assign a_data  = rdata[0];
  assign b_valid = rvalid[1];
  assign b_data  = rdata[1];
endmodule

// File: rtl/rng_splitter_chk.sv
module rng_splitter_chk #(
  parameter int PW = 4
) (
  input logic          src_clk,
  input logic          src_rst_n,
  input logic          src_valid,
  input logic          src_ready,
  input logic [1:0]    room,
  input logic [1:0]    wen,
  input logic [1:0]    full,
  input logic [1:0]    rclk,
  input logic [1:0]    rrst_n,
  input logic [1:0]    rgate,
  input logic [1:0]    rvalid,
  input logic [1:0]    ren,
  input logic [PW-1:0] rpos [2]
);
  assert_single_fill_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (src_valid && src_ready) |-> $countones(wen) == 1);

  assert_no_take_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    !(src_valid && src_ready) |-> wen == 2'b00);

  assert_ready_room_R3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (full != 2'b11) |-> src_ready);

  assert_alternate_R4: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    ($past(src_valid && src_ready && room == 2'b11) && src_valid && src_ready && room == 2'b11)
      |-> wen != $past(wen));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    assert_no_overflow_R7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      wen[i] |-> !full[i]);

    assert_no_underflow_R7: assert property (@(posedge rclk[i]) disable iff (!rrst_n[i])
      ren[i] |-> (rvalid[i] && rgate[i]));

    assert_gate_hold_R6: assert property (@(posedge rclk[i]) disable iff (!rrst_n[i])
      !rgate[i] |=> $stable(rpos[i]));
  end
endmodule

bind rng_splitter rng_splitter_chk #(.PW(PW)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid), .src_ready(src_ready),
  .room(room), .wen(wen), .full(full), .rclk(rclk), .rrst_n(rrst_n), .rgate(rgate),
  .rvalid(rvalid), .ren(ren), .rpos(rpos)
);

// File: tb/sim_rng_splitter.sv
`timescale 1ns/1ps
module sim_rng_splitter;
  logic src_clk = 0, a_clk = 0, b_clk = 0;
  logic src_arst_n = 0, a_arst_n = 0, b_arst_n = 0;
  logic src_valid = 0, a_gate = 0, a_ready = 0, b_gate = 0, b_ready = 0;
  logic [15:0] src_data = 0;
  logic src_ready, a_valid, b_valid;
  logic [15:0] a_data, b_data;

  always #2 src_clk = ~src_clk;
  always #3 a_clk = ~a_clk;
  always #5 b_clk = ~b_clk;

  rng_splitter u0 (.*);

  int n_run = 0, n_fail = 0;
  int k = 0, n_got = 0;
  int idx_of [int];
  bit done [int];
  int last [2] = '{-1, -1};
  int cnt [2] = '{0, 0};
  bit fill_chk = 1;
  bit src_en = 0, src_rand = 0, ga = 0, gb = 0, a_rand = 0;
  int a_mode = 0, b_mode = 0;

  function automatic logic [15:0] f(input int n);
    return 16'((n * 40503 + 7) & 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic take(input int p, input logic [15:0] v);
    int ix;
    if (!idx_of.exists(int'(v))) begin
      chk(0, "R7 item never accepted", int'(v), -1);
      return;
    end
    ix = idx_of[int'(v)];
    chk(!done.exists(ix), "R8 duplicate delivery", ix, -1);
    done[ix] = 1;
    chk(ix > last[p], "R5 per-port order", ix, last[p] + 1);
    last[p] = ix;
    if (fill_chk && cnt[p] < 8) chk(ix == 2 * cnt[p] + p, "R4 round-robin split", ix, 2 * cnt[p] + p);
    cnt[p]++;
    n_got++;
  endtask

  initial forever begin
    @(negedge src_clk);
    src_valid = src_en && (!src_rand || ($urandom % 3 != 0));
    src_data  = f(k);
    #1;
    if (src_valid && src_ready) begin
      idx_of[int'(src_data)] = k;
      k++;
    end
  end

  initial begin : drv_a
    int c = 0;
    forever begin
      @(negedge a_clk);
      a_gate  = a_rand ? ($urandom % 4 != 0) : ga;
      a_ready = (a_mode == 0) ? 1'b1 : (c % 3 == 0);
      c++;
      #1;
      if (a_valid && a_ready && a_gate) take(0, a_data);
    end
  end

  initial begin : drv_b
    int c = 0;
    forever begin
      @(negedge b_clk);
      b_gate  = gb;
      b_ready = (b_mode == 0) ? 1'b1 : (c % 30 >= 20);
      c++;
      #1;
      if (b_valid && b_ready && b_gate) take(1, b_data);
    end
  end

  initial begin
    #600000;
    chk(0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge src_clk);
    #1;
    chk(src_ready == 0, "R1 src_ready in reset", src_ready, 0);
    chk(a_valid == 0, "R1 a_valid in reset", a_valid, 0);
    chk(b_valid == 0, "R1 b_valid in reset", b_valid, 0);
    a_arst_n = 1; b_arst_n = 1;
    @(negedge src_clk);
    src_arst_n = 1;
    #0.5;
    chk(src_ready == 0, "R9 ready held at release", src_ready, 0);
    @(posedge src_clk); #0.5;
    chk(src_ready == 0, "R9 ready held after first edge", src_ready, 0);
    @(posedge src_clk); #0.5;
    chk(src_ready == 1, "R9 ready after second edge", src_ready, 1);
    chk(a_valid == 0 && b_valid == 0, "R1 outputs empty after reset", {a_valid, b_valid}, 0);

    src_en = 1;
    repeat (80) @(negedge src_clk);
    #1;
    chk(k == 16, "R3 accepted while stalled", k, 16);
    chk(src_ready == 0, "R7 full offer not taken", src_ready, 0);
    chk(a_valid == 1 && b_valid == 1, "R5 valid while buffered", {a_valid, b_valid}, 3);
    chk(n_got == 0, "R6 no pop while gated", n_got, 0);

    ga = 1;
    repeat (100) @(negedge src_clk);
    chk(cnt[0] >= 8, "R6 A drains after gate opens", cnt[0], 8);
    chk(cnt[1] == 0, "R6 B held while gated", cnt[1], 0);
    chk(b_valid == 1, "R6 B data retained", b_valid, 1);

    gb = 1;
    repeat (200) @(negedge src_clk);
    chk(cnt[1] >= 8, "R5 B drains", cnt[1], 8);
    fill_chk = 0;

    src_rand = 1; a_mode = 1; b_mode = 1; a_rand = 1;
    repeat (4000) @(negedge src_clk);

    src_en = 0; a_rand = 0; ga = 1;
    repeat (600) @(negedge src_clk);
    #1;
    chk(n_got == k, "R8 all accepted delivered", n_got, k);
    chk(a_valid == 0 && b_valid == 0, "R7 empty after drain", {a_valid, b_valid}, 0);
    for (int j = 0; j < k; j++)
      if (!done.exists(j)) chk(0, "R8 item lost", j, -1);
    chk(cnt[0] > 0 && cnt[1] > 0, "R2 both ports fed", cnt[0] * cnt[1], 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule